// File: doc/BRIEF.md
# Inter-Processor Doorbell Register Block

This block lets one processor raise interrupts on up to eleven remote agents and collect interrupts coming back from them. A word-wide register bus with aligned accesses gives software a small register set. A write to the trigger word fires one-cycle pulses on the selected outbound lines. Inbound lines from the agents are held in a sticky pending word that software clears by writing ones.

A per-agent mask gates the pending bits into one combined, registered interrupt output. Software cannot write the mask directly. It changes it only through an unmask word and a re-mask word, so enabling one source can never disturb another. The pending word is also driven out, one bit per agent, for observers. A read-only sampling word shows the level of a second set of inbound lines.

Only eleven of the 32 bit positions carry an agent. Agent k sits at the k-th set bit of the implemented mask 0x0F0F0301, which gives bits 0, 8, 9, 16 to 19 and 24 to 27. Every other position reads as zero and ignores writes.

Top module: `doorbell_hub`

## Requirements
- R1: After reset the pending word (byte offset 0x10) reads 0, the mask word (0x14) reads 0x0F0F0301 (all agents masked), and `doorbell_out`, `pend_out` and `irq_o` are 0.
- R2: Agent k (k = 0..10) maps to bit position 0, 8, 9, 16, 17, 18, 19, 24, 25, 26, 27 in that order. Every other bit position reads as 0 in every word, and the value written there has no effect.
- R3: A write to offset 0x00 drives each written agent bit onto `doorbell_out` for exactly the one cycle that follows the write. The outputs are 0 in every other cycle, and offset 0x00 reads 0.
- R4: An agent's `doorbell_in` line that is high in a cycle sets that agent's pending bit. The bit is visible at offset 0x10 and on `pend_out` from the next cycle, and it stays set after the line falls.
- R5: Writing 1 to a pending bit at offset 0x10 clears it from the next cycle. Writing 0 leaves it unchanged.
- R6: When a clear write and a high `doorbell_in` line hit the same agent in the same cycle, the pending bit stays set.
- R7: Writing ones to offset 0x18 clears the matching mask bits, and writing ones to offset 0x1C sets them. Both offsets read 0. Writes to the mask word at offset 0x14 itself have no effect.
- R8: `irq_o` is registered. In each cycle it equals the OR over agents of (pending and not masked), taken from the state of the previous cycle.
- R9: Offset 0x04 reads, at each agent position, the level that `peek_in` had one cycle earlier. Writes to offset 0x04 have no effect.
- R10: Offsets 0x08 and 0x0C read 0, and writes to them change no state and fire no pulse.
- R11: An access whose two low address bits are not zero is ignored. It reads 0, changes no state and fires no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access valid in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (5) | Byte address of the access |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, combinational for the current access |
| doorbell_in | input | AGENT_N (11) | Inbound interrupt lines, one per agent |
| peek_in | input | AGENT_N (11) | Inbound lines sampled into the read-only word |
| doorbell_out | output | AGENT_N (11) | Outbound one-cycle trigger pulses |
| pend_out | output | AGENT_N (11) | Pending bits, one per agent |
| irq_o | output | 1 | Combined interrupt, registered |

## Verification
The trigger word is written with all ones, with a sparse mixed pattern and with reserved bits only. These three cases separate correct bit placement, the one-cycle pulse length and leaks from reserved positions. Pending bits are driven by single-cycle inbound pulses, by clear writes of zero and of one, and by a clear that collides with a new assertion, which shows whether the set wins. The unmask, re-mask, direct-write and misaligned cases each test whether the mask moves only through its own two words, and the interrupt is sampled both in the cycle of a change and in the cycle after, so that its one-cycle latency is checked. A long random phase mixes all writes with sparse inbound traffic against a bench model.

// File: rtl/dbh_pkg.sv
package dbh_pkg;

   // Word slot selected by byte address bits [4:2]
   typedef enum logic [2:0] {
      SLOT_TRIG = 3'd0,
      SLOT_PEEK = 3'd1,
      SLOT_PEND = 3'd4,
      SLOT_MASK = 3'd5,
      SLOT_UNMASK = 3'd6,
      SLOT_REMASK = 3'd7
   } slot_e;

   localparam int SLOT_LSB = 2;
   localparam int SLOT_W = 3;
   localparam int MIN_ADDR_W = SLOT_LSB + SLOT_W;

   // Number of set bits of m strictly below position b
   function automatic int ones_below(input logic [63:0] m, input int b);
      int c;
      c = 0;
      for (int k = 0; k < 64; k++) begin
         if (k < b && m[k]) c++;
      end
      return c;
   endfunction

   function automatic int ones_total(input logic [63:0] m);
      return ones_below(m, 64);
   endfunction

endpackage

// File: rtl/dbh_pulse.sv
module dbh_pulse #(
   parameter int WIDTH = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fire_i,
   input  logic [WIDTH-1:0] bits_i,
   output logic [WIDTH-1:0] pulse_o
);

   // One-cycle pulse: loaded on a write, dropped on the next edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pulse_o <= '0;
      else        pulse_o <= fire_i ? bits_i : '0;
   end

endmodule

// File: rtl/dbh_status.sv
module dbh_status #(
   parameter int WIDTH = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] set_i,
   input  logic [WIDTH-1:0] clr_i,
   output logic [WIDTH-1:0] pend_o
);

   // Clear first, then set: a simultaneous assertion survives
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_o <= '0;
      else        pend_o <= (pend_o & ~clr_i) | set_i;
   end

endmodule

// File: rtl/dbh_mask.sv
module dbh_mask #(
   parameter int WIDTH = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] unmask_i,
   input  logic [WIDTH-1:0] remask_i,
   output logic [WIDTH-1:0] mask_o
);

   // Reset masks every source; re-mask wins on overlap
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask_o <= '1;
      else        mask_o <= (mask_o & ~unmask_i) | remask_i;
   end

endmodule

// File: rtl/dbh_irq_merge.sv
module dbh_irq_merge #(
   parameter int WIDTH = 11,
   parameter bit REG_OUT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] pend_i,
   input  logic [WIDTH-1:0] mask_i,
   output logic             irq_o
);

   logic any_live;
   assign any_live = |(pend_i & ~mask_i);

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_o <= 1'b0;
            else        irq_o <= any_live;
         end
      end else begin : g_comb
         assign irq_o = any_live;
      end
   endgenerate

endmodule

// File: rtl/doorbell_hub.sv
module doorbell_hub #(
   parameter int              ADDR_W    = 5,
   parameter int              DATA_W    = 32,
   parameter int              AGENT_N   = 11,
   parameter logic [DATA_W-1:0] IMPL_MASK = 32'h0F0F_0301,
   parameter bit              IRQ_REG   = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_sel,
   input  logic               bus_we,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   input  logic [AGENT_N-1:0] doorbell_in,
   input  logic [AGENT_N-1:0] peek_in,
   output logic [AGENT_N-1:0] doorbell_out,
   output logic [AGENT_N-1:0] pend_out,
   output logic               irq_o
);

   localparam int SLOT_HI = dbh_pkg::SLOT_LSB + dbh_pkg::SLOT_W - 1;

   // Elaboration-time parameter checks
   generate
      if (ADDR_W < dbh_pkg::MIN_ADDR_W) begin : g_bad_addr
         $error("doorbell_hub: ADDR_W too small for the register map");
      end
      if (DATA_W > 64 || DATA_W < 8) begin : g_bad_data
         $error("doorbell_hub: DATA_W out of range");
      end
      if (dbh_pkg::ones_total(64'(IMPL_MASK)) != AGENT_N) begin : g_bad_agents
         $error("doorbell_hub: IMPL_MASK popcount must equal AGENT_N");
      end
   endgenerate

   // Address decode
   dbh_pkg::slot_e slot;
   logic acc_ok, wr_ok, rd_ok;
   logic wr_trig, wr_pend, wr_unmask, wr_remask;

   assign slot   = dbh_pkg::slot_e'(bus_addr[SLOT_HI:dbh_pkg::SLOT_LSB]);
   assign acc_ok = bus_sel && (bus_addr[dbh_pkg::SLOT_LSB-1:0] == '0)
                   && ((bus_addr >> dbh_pkg::MIN_ADDR_W) == '0);
   assign wr_ok  = acc_ok && bus_we;
   assign rd_ok  = acc_ok && !bus_we;

   assign wr_trig   = wr_ok && (slot == dbh_pkg::SLOT_TRIG);
   assign wr_pend   = wr_ok && (slot == dbh_pkg::SLOT_PEND);
   assign wr_unmask = wr_ok && (slot == dbh_pkg::SLOT_UNMASK);
   assign wr_remask = wr_ok && (slot == dbh_pkg::SLOT_REMASK);

   // Compress the write word into agent order, expand state back out
   logic [AGENT_N-1:0] wr_vec;
   logic [AGENT_N-1:0] pend_q, mask_q, peek_q;
   logic [DATA_W-1:0]  pend_word, mask_word, peek_word;
   logic [DATA_W-1:0]  unused_rsvd_wdata;

   assign unused_rsvd_wdata = bus_wdata & ~IMPL_MASK;

   generate
      for (genvar b = 0; b < DATA_W; b++) begin : g_bit
         if (IMPL_MASK[b]) begin : g_used
            localparam int IDX = dbh_pkg::ones_below(64'(IMPL_MASK), b);
            assign wr_vec[IDX]  = bus_wdata[b];
            assign pend_word[b] = pend_q[IDX];
            assign mask_word[b] = mask_q[IDX];
            assign peek_word[b] = peek_q[IDX];
         end else begin : g_rsvd
            assign pend_word[b] = 1'b0;
            assign mask_word[b] = 1'b0;
            assign peek_word[b] = 1'b0;
         end
      end
   endgenerate

   // Outbound pulses
   dbh_pulse #(.WIDTH(AGENT_N)) u_pulse (
      .clk    (clk),
      .rst_n  (rst_n),
      .fire_i (wr_trig),
      .bits_i (wr_vec),
      .pulse_o(doorbell_out)
   );

   // Sticky pending bits
   logic [AGENT_N-1:0] clr_vec;
   assign clr_vec = wr_pend ? wr_vec : '0;

   dbh_status #(.WIDTH(AGENT_N)) u_status (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (doorbell_in),
      .clr_i (clr_vec),
      .pend_o(pend_q)
   );

   // Mask changed only through the unmask / re-mask words
   logic [AGENT_N-1:0] unmask_vec, remask_vec;
   assign unmask_vec = wr_unmask ? wr_vec : '0;
   assign remask_vec = wr_remask ? wr_vec : '0;

   dbh_mask #(.WIDTH(AGENT_N)) u_mask (
      .clk     (clk),
      .rst_n   (rst_n),
      .unmask_i(unmask_vec),
      .remask_i(remask_vec),
      .mask_o  (mask_q)
   );

   dbh_irq_merge #(.WIDTH(AGENT_N), .REG_OUT(IRQ_REG)) u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .pend_i(pend_q),
      .mask_i(mask_q),
      .irq_o (irq_o)
   );

   // Sampled observation lines
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) peek_q <= '0;
      else        peek_q <= peek_in;
   end

   assign pend_out = pend_q;

   // Read mux; trigger, unmask and re-mask words read as zero
   always_comb begin
      bus_rdata = '0;
      if (rd_ok) begin
         case (slot)
            dbh_pkg::SLOT_PEEK: bus_rdata = peek_word;
            dbh_pkg::SLOT_PEND: bus_rdata = pend_word;
            dbh_pkg::SLOT_MASK: bus_rdata = mask_word;
            default:            bus_rdata = '0;
         endcase
      end
   end

endmodule

// File: rtl/dbh_checker.sv
module dbh_checker #(
   parameter int              ADDR_W    = 5,
   parameter int              DATA_W    = 32,
   parameter int              AGENT_N   = 11,
   parameter logic [DATA_W-1:0] IMPL_MASK = 32'h0F0F_0301,
   parameter bit              IRQ_REG   = 1'b1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               bus_sel,
   input logic               bus_we,
   input logic [ADDR_W-1:0]  bus_addr,
   input logic [DATA_W-1:0]  bus_rdata,
   input logic [AGENT_N-1:0] doorbell_in,
   input logic [AGENT_N-1:0] doorbell_out,
   input logic [AGENT_N-1:0] pend_out,
   input logic               irq_o,
   input logic [AGENT_N-1:0] mask_v
);

   logic trig_wr, clr_wr, mask_wr;
   assign trig_wr = bus_sel && bus_we && (bus_addr == ADDR_W'(0));
   assign clr_wr  = bus_sel && bus_we && (bus_addr == ADDR_W'(16));
   assign mask_wr = bus_sel && bus_we &&
                    ((bus_addr == ADDR_W'(24)) || (bus_addr == ADDR_W'(28)));

   // R2: reserved positions never read back as one
   a_r2_rsvd_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rdata & ~IMPL_MASK) == '0);

   // R3: no pulse follows a cycle without a trigger write
   a_r3_pulse_only_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      !trig_wr |=> doorbell_out == '0);

   // R5: without a clear write no pending bit drops
   a_r5_pend_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_wr |=> (pend_out & $past(pend_out)) == $past(pend_out));

   // R4 / R6: an inbound high always leaves its bit set, even against a clear
   a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (pend_out & $past(doorbell_in)) == $past(doorbell_in));

   // R7: mask moves only through the unmask / re-mask words
   a_r7_mask_guarded: assert property (@(posedge clk) disable iff (!rst_n)
      !mask_wr |=> $stable(mask_v));

   generate
      if (IRQ_REG) begin : g_irq_reg
         // R8: registered combination of pending and mask
         a_r8_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> irq_o == $past(|(pend_out & ~mask_v)));
      end else begin : g_irq_comb
         a_r8_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
            irq_o == |(pend_out & ~mask_v));
      end
   endgenerate

endmodule

bind doorbell_hub dbh_checker #(
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .AGENT_N  (AGENT_N),
   .IMPL_MASK(IMPL_MASK),
   .IRQ_REG  (IRQ_REG)
) u_dbh_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_sel     (bus_sel),
   .bus_we      (bus_we),
   .bus_addr    (bus_addr),
   .bus_rdata   (bus_rdata),
   .doorbell_in (doorbell_in),
   .doorbell_out(doorbell_out),
   .pend_out    (pend_out),
   .irq_o       (irq_o),
   .mask_v      (mask_q)
);

// File: tb/doorbell_hub_tb.sv
module doorbell_hub_tb;

   localparam int CLK_PERIOD = 10;
   localparam int NA = 11;
   localparam int POS [NA] = '{0, 8, 9, 16, 17, 18, 19, 24, 25, 26, 27};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_sel = 1'b0;
   logic          bus_we = 1'b0;
   logic [4:0]    bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [NA-1:0] doorbell_in = '0;
   logic [NA-1:0] peek_in = '0;
   logic [NA-1:0] doorbell_out;
   logic [NA-1:0] pend_out;
   logic          irq_o;

   int checks = 0;
   int failures = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   doorbell_hub u_dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .doorbell_in(doorbell_in), .peek_in(peek_in),
      .doorbell_out(doorbell_out), .pend_out(pend_out), .irq_o(irq_o)
   );

   function automatic logic [NA-1:0] squeeze(input logic [31:0] w);
      logic [NA-1:0] v;
      for (int k = 0; k < NA; k++) v[k] = w[POS[k]];
      return v;
   endfunction

   function automatic logic [31:0] spread(input logic [NA-1:0] v);
      logic [31:0] w;
      w = '0;
      for (int k = 0; k < NA; k++) w[POS[k]] = v[k];
      return w;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Write: drive at a falling edge, state updates at the next rising edge
   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [31:0] r;
      logic [NA-1:0] m_st, m_mask, m_trig, n_clr, din;
      logic m_irq, n_irq;
      logic [4:0] a;
      logic [31:0] d;
      logic s;
      int op;
      void'($urandom(32'd1234));

      @(negedge clk);
      do_reset();

      // R1 reset state
      rd(5'h10, r); chk("R1 pending", r, 32'h0);
      rd(5'h14, r); chk("R1 mask", r, 32'h0F0F_0301);
      chk("R1 irq", {31'b0, irq_o}, 32'h0);
      chk("R1 pulses", {21'b0, doorbell_out}, 32'h0);
      chk("R1 pend_out", {21'b0, pend_out}, 32'h0);

      // R3 trigger pulses
      wr(5'h00, 32'hFFFF_FFFF);
      chk("R3 all ones pulse", {21'b0, doorbell_out}, 32'h7FF);
      @(negedge clk);
      chk("R3 pulse ends", {21'b0, doorbell_out}, 32'h0);
      wr(5'h00, 32'h0A0A_0201);
      chk("R3 sparse pulse", {21'b0, doorbell_out}, {21'b0, squeeze(32'h0A0A_0201)});
      rd(5'h00, r); chk("R3 reads zero", r, 32'h0);
      // R2 reserved-only trigger
      wr(5'h00, 32'hF0F0_FCFE);
      chk("R2 reserved pulse", {21'b0, doorbell_out}, 32'h0);

      // R4 inbound set, sticky
      doorbell_in = 11'h005;
      @(negedge clk);
      doorbell_in = '0;
      chk("R4 pend_out", {21'b0, pend_out}, 32'h005);
      rd(5'h10, r); chk("R4 pending word", r, spread(11'h005));
      chk("R8 masked irq", {31'b0, irq_o}, 32'h0);

      // R7 unmask agent 0, R8 latency
      wr(5'h18, spread(11'h001));
      chk("R8 irq not yet", {31'b0, irq_o}, 32'h0);
      @(negedge clk);
      chk("R8 irq raised", {31'b0, irq_o}, 32'h1);
      rd(5'h14, r); chk("R7 mask after unmask", r, 32'h0F0F_0300);
      rd(5'h18, r); chk("R7 unmask reads zero", r, 32'h0);
      rd(5'h1C, r); chk("R7 remask reads zero", r, 32'h0);
      wr(5'h14, 32'h0);
      rd(5'h14, r); chk("R7 mask word read-only", r, 32'h0F0F_0300);

      // R5 write-one-to-clear
      wr(5'h10, 32'h0);
      chk("R5 zero write keeps", {21'b0, pend_out}, 32'h005);
      wr(5'h10, spread(11'h001));
      chk("R5 cleared", {21'b0, pend_out}, 32'h004);
      chk("R8 irq still high", {31'b0, irq_o}, 32'h1);
      @(negedge clk);
      chk("R8 irq dropped", {31'b0, irq_o}, 32'h0);

      // R6 set beats clear in the same cycle
      doorbell_in = 11'h004;
      wr(5'h10, spread(11'h004));
      doorbell_in = '0;
      chk("R6 set wins", {21'b0, pend_out}, 32'h004);
      wr(5'h10, spread(11'h004));
      chk("R6 later clear", {21'b0, pend_out}, 32'h0);

      // R7 re-mask all
      wr(5'h1C, 32'hFFFF_FFFF);
      rd(5'h14, r); chk("R7 remask", r, 32'h0F0F_0301);

      // R9 observation word
      peek_in = 11'h555;
      @(negedge clk);
      rd(5'h04, r); chk("R9 peek", r, spread(11'h555));
      wr(5'h04, 32'h0);
      rd(5'h04, r); chk("R9 peek write ignored", r, spread(11'h555));
      peek_in = 11'h2AA;
      @(negedge clk);
      rd(5'h04, r); chk("R9 peek follows", r, spread(11'h2AA));

      // R10 unmapped offsets
      wr(5'h08, 32'hFFFF_FFFF);
      chk("R10 no pulse", {21'b0, doorbell_out}, 32'h0);
      wr(5'h0C, 32'hFFFF_FFFF);
      rd(5'h08, r); chk("R10 read 0x08", r, 32'h0);
      rd(5'h0C, r); chk("R10 read 0x0C", r, 32'h0);
      rd(5'h14, r); chk("R10 mask untouched", r, 32'h0F0F_0301);
      chk("R10 pending untouched", {21'b0, pend_out}, 32'h0);

      // R11 misaligned accesses
      doorbell_in = 11'h002;
      @(negedge clk);
      doorbell_in = '0;
      wr(5'h11, 32'hFFFF_FFFF);
      chk("R11 misaligned clear ignored", {21'b0, pend_out}, 32'h002);
      rd(5'h11, r); chk("R11 misaligned read", r, 32'h0);
      wr(5'h19, 32'hFFFF_FFFF);
      rd(5'h14, r); chk("R11 misaligned unmask ignored", r, 32'h0F0F_0301);
      wr(5'h01, 32'hFFFF_FFFF);
      chk("R11 misaligned trigger", {21'b0, doorbell_out}, 32'h0);

      // Random phase against a bench model
      do_reset();
      m_st = '0; m_mask = '1; m_trig = '0; m_irq = 1'b0;
      for (int it = 0; it < 4000; it++) begin
         @(negedge clk);
         if (it > 0) begin
            chk("R4 random pending", {21'b0, pend_out}, {21'b0, m_st});
            chk("R8 random irq", {31'b0, irq_o}, {31'b0, m_irq});
            chk("R3 random pulse", {21'b0, doorbell_out}, {21'b0, m_trig});
         end
         op = $urandom_range(0, 7);
         d  = $urandom;
         din = ($urandom_range(0, 3) == 0) ? NA'($urandom) : '0;
         s = (op < 6);
         case (op)
            0: a = 5'h00;
            1: a = 5'h10;
            2: a = 5'h18;
            3: a = 5'h1C;
            4: a = 5'h14;
            default: a = 5'h08;
         endcase
         bus_sel = s; bus_we = s; bus_addr = a; bus_wdata = d;
         doorbell_in = din;
         n_irq = |(m_st & ~m_mask);
         n_clr = (s && a == 5'h10) ? squeeze(d) : '0;
         m_st  = (m_st & ~n_clr) | din;
         if (s && a == 5'h18) m_mask = m_mask & ~squeeze(d);
         if (s && a == 5'h1C) m_mask = m_mask | squeeze(d);
         m_trig = (s && a == 5'h00) ? squeeze(d) : '0;
         m_irq = n_irq;
      end
      @(negedge clk);
      chk("R5 random final pending", {21'b0, pend_out}, {21'b0, m_st});
      bus_sel = 1'b0; bus_we = 1'b0; doorbell_in = '0;

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule